// File: doc/BRIEF.md
# Chip RAM Window Alias Decoder

This block sits on the processor side of a system whose lowest 2 MB of byte addresses, 0x000000 to 0x1FFFFF, all belong to chip memory. The processor's address is folded onto the installed RAM the way the video/DMA controller folds it. A controller revision with a short address reach ignores the high window bits, so the installed RAM image shows up again at regular strides through the window. Within one image, offsets past the installed RAM reach no bank and read as an idle bus.

The decoder is combinational from address to RAM offset, RAM select, open-bus flag, write enable and returned read data. A read from an unbacked address returns a fixed idle pattern, and a write to one is dropped. The canonical chip address is reported next to the bus address, with a flag for when the two differ. Four watchpoint slots compare each access against both addresses, so a watch set on any alias of a RAM cell still fires. Each slot raises a one-cycle hit pulse on the clock edge after the access.

Top module: `chip_alias_decoder`

## Requirements
- R1: An address with any bit at or above bit 21 set lies outside the window. For it, `ram_sel`, `open_bus` and `ram_we` stay low and no watchpoint fires.
- R2: With `rev_sel` = 0 (512 KB reach), `ram_offset` equals the address ANDed with 0x07FFFF, so the image repeats at 0x080000, 0x100000 and 0x180000.
- R3: With `rev_sel` = 1 (1 MB reach), `ram_offset` equals the address ANDed with 0x0FFFFF, so the image repeats once, at 0x100000.
- R4: With `rev_sel` = 2 or 3 (2 MB reach), `ram_offset` equals the address ANDed with 0x1FFFFF, so there is no repeat.
- R5: Inside the window, `ram_sel` is high when `ram_offset` is below the installed size (`size_sel` = 0 gives 0x080000, `size_sel` = 1 gives 0x100000). Otherwise `open_bus` is high. The two flags are never high together.
- R6: A write to 0x0FFFFC with 512 KB reach and 512 KB installed gives `ram_offset` 0x7FFFC with `ram_we` high.
- R7: `cpu_rdata` is `ram_rdata` when `ram_sel` is high and the idle value (default all ones) otherwise. `ram_we` is high only for a valid write with `ram_sel` high, so writes to open bus are dropped.
- R8: `canon_addr` is `ram_offset` zero-extended. Inside the window, `aliased` is high exactly when `canon_addr` differs from `bus_addr`.
- R9: A watchpoint slot takes its address, enable and mode from the configuration port on the clock edge where `wp_cfg_we` is high and `wp_cfg_idx` selects it. Reset clears every enable.
- R10: For a valid in-window access, slot k raises `wp_hit[k]` for exactly one cycle, on the edge after the access, when all of these hold:
  - the slot is enabled;
  - its mode permits the access (mode bit 0 for reads, mode bit 1 for writes);
  - its address equals either `bus_addr` or `canon_addr`.
- R11: A disabled slot, or a slot whose mode excludes the access direction, raises no hit even when its address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | An access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Processor byte address |
| rev_sel | input | 2 | Controller reach: 0 = 512 KB, 1 = 1 MB, 2/3 = 2 MB |
| size_sel | input | 1 | Installed chip RAM: 0 = 512 KB, 1 = 1 MB |
| ram_rdata | input | 16 | Data returned by chip RAM |
| cpu_rdata | output | 16 | Data returned to the processor |
| ram_sel | output | 1 | Offset is backed by installed RAM |
| open_bus | output | 1 | In-window address with no RAM behind it |
| ram_we | output | 1 | Write strobe toward chip RAM |
| ram_offset | output | 21 | Folded physical RAM offset |
| canon_addr | output | 24 | Canonical chip address |
| aliased | output | 1 | Bus address is a repeat of the canonical address |
| wp_cfg_we | input | 1 | Load one watchpoint slot |
| wp_cfg_idx | input | 2 | Slot being loaded |
| wp_cfg_addr | input | 24 | Watched byte address |
| wp_cfg_en | input | 1 | Slot enable |
| wp_cfg_mode | input | 2 | Bit 0 watches reads, bit 1 watches writes |
| wp_hit | output | 4 | Registered per-slot hit pulse |

## Verification
The folded offset, both select flags, the write strobe, the read data and the alias flag are all due in the same cycle as the address. The bench drives each access on a falling edge and compares these outputs one nanosecond later, before any rising edge. Watchpoint hits are due on the rising edge after the access, so the bench samples `wp_hit` one nanosecond after that edge and compares it with its own slot model. A configuration write takes effect on its own rising edge, and it is always complete before the first access that relies on it.

// File: rtl/chip_alias_pkg.sv
package chip_alias_pkg;

  // Reach selector values
  typedef enum logic [1:0] {
    REACH_512K = 2'd0,
    REACH_1M   = 2'd1,
    REACH_2M   = 2'd2,
    REACH_2M_B = 2'd3
  } reach_e;

  // Watch mode bit positions
  localparam int unsigned WMODE_RD = 0;
  localparam int unsigned WMODE_WR = 1;

  // Address bits decoded by the controller: base plus one per revision step,
  // clipped to the window width.
  function automatic int unsigned reach_bits(input logic [1:0] rev,
                                             input int unsigned base_bits,
                                             input int unsigned win_bits);
    int unsigned b;
    b = base_bits + ((rev >= 2'd2) ? 2 : int'(rev));
    if (b > win_bits) b = win_bits;
    return b;
  endfunction

  function automatic logic [31:0] reach_mask(input logic [1:0] rev,
                                             input int unsigned base_bits,
                                             input int unsigned win_bits);
    return (32'd1 << reach_bits(rev, base_bits, win_bits)) - 32'd1;
  endfunction

  // First offset past the installed RAM.
  function automatic logic [31:0] fitted_limit(input logic size_sel,
                                               input int unsigned base_bits);
    return 32'd1 << (base_bits + (size_sel ? 1 : 0));
  endfunction

endpackage

// File: rtl/chip_fold.sv
module chip_fold
  import chip_alias_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned WIN_BITS  = 21,
  parameter int unsigned BASE_BITS = 19
) (
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          rev_sel,
  input  logic                size_sel,
  output logic                in_window,
  output logic [WIN_BITS-1:0] ram_offset,
  output logic [ADDR_W-1:0]   canon_addr,
  output logic                ram_hit,
  output logic                hole,
  output logic                aliased
);

  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic [WIN_BITS-1:0] fold_mask;
  logic [WIN_BITS-1:0] folded;
  logic                below_fit;

  assign in_window = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
  assign fold_mask = WIN_BITS'(reach_mask(rev_sel, BASE_BITS, WIN_BITS));
  assign folded    = bus_addr[WIN_BITS-1:0] & fold_mask;
  assign below_fit = (32'(folded) < fitted_limit(size_sel, BASE_BITS));

  assign ram_offset = folded;
  assign canon_addr = {{HI_W{1'b0}}, folded};
  assign ram_hit    = in_window & below_fit;
  assign hole       = in_window & ~below_fit;
  assign aliased    = in_window & (folded != bus_addr[WIN_BITS-1:0]);

endmodule

// File: rtl/chip_wp_slot.sv
module chip_wp_slot
  import chip_alias_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_in_window,
  input  logic [ADDR_W-1:0] acc_bus_addr,
  input  logic [ADDR_W-1:0] acc_canon_addr,
  output logic              hit
);

  logic [ADDR_W-1:0] watch_addr;
  logic              watch_en;
  logic [1:0]        watch_mode;
  logic              dir_ok;
  logic              addr_match;
  logic              match_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      watch_addr <= '0;
      watch_en   <= 1'b0;
      watch_mode <= 2'b00;
    end else if (cfg_load) begin
      watch_addr <= cfg_addr;
      watch_en   <= cfg_en;
      watch_mode <= cfg_mode;
    end
  end

  assign dir_ok     = acc_write ? watch_mode[WMODE_WR] : watch_mode[WMODE_RD];
  assign addr_match = (watch_addr == acc_bus_addr) | (watch_addr == acc_canon_addr);
  assign match_now  = acc_valid & acc_in_window & watch_en & dir_ok & addr_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= match_now;
  end

  // R10
  hit_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_valid));

  // R1
  hit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_in_window));

  // R11
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !watch_en) |=> !hit);

endmodule

// File: rtl/chip_wp_bank.sv
module chip_wp_bank #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NUM_WP = 4,
  localparam int unsigned IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_in_window,
  input  logic [ADDR_W-1:0] acc_bus_addr,
  input  logic [ADDR_W-1:0] acc_canon_addr,
  output logic [NUM_WP-1:0] hits
);

  logic [NUM_WP-1:0] slot_load;

  for (genvar i = 0; i < NUM_WP; i++) begin : g_slot
    assign slot_load[i] = cfg_we & (cfg_idx == IDX_W'(i));

    chip_wp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_load      (slot_load[i]),
      .cfg_addr      (cfg_addr),
      .cfg_en        (cfg_en),
      .cfg_mode      (cfg_mode),
      .acc_valid     (acc_valid),
      .acc_write     (acc_write),
      .acc_in_window (acc_in_window),
      .acc_bus_addr  (acc_bus_addr),
      .acc_canon_addr(acc_canon_addr),
      .hit           (hits[i])
    );
  end

  // R9
  one_slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_load));

endmodule

// File: rtl/chip_alias_decoder.sv
module chip_alias_decoder
  import chip_alias_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned WIN_BITS  = 21,
  parameter int unsigned BASE_BITS = 19,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_WP    = 4,
  parameter logic [DATA_W-1:0] IDLE_VALUE = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [1:0]                 rev_sel,
  input  logic                       size_sel,
  input  logic [DATA_W-1:0]          ram_rdata,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic                       ram_sel,
  output logic                       open_bus,
  output logic                       ram_we,
  output logic [WIN_BITS-1:0]        ram_offset,
  output logic [ADDR_W-1:0]          canon_addr,
  output logic                       aliased,
  input  logic                       wp_cfg_we,
  input  logic [$clog2(NUM_WP)-1:0]  wp_cfg_idx,
  input  logic [ADDR_W-1:0]          wp_cfg_addr,
  input  logic                       wp_cfg_en,
  input  logic [1:0]                 wp_cfg_mode,
  output logic [NUM_WP-1:0]          wp_hit
);

  logic in_window;
  logic fold_hit;
  logic fold_hole;

  chip_fold #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .BASE_BITS(BASE_BITS)
  ) u_fold (
    .bus_addr  (bus_addr),
    .rev_sel   (rev_sel),
    .size_sel  (size_sel),
    .in_window (in_window),
    .ram_offset(ram_offset),
    .canon_addr(canon_addr),
    .ram_hit   (fold_hit),
    .hole      (fold_hole),
    .aliased   (aliased)
  );

  assign ram_sel   = fold_hit;
  assign open_bus  = fold_hole;
  assign ram_we    = bus_valid & bus_write & fold_hit;
  assign cpu_rdata = fold_hit ? ram_rdata : IDLE_VALUE;

  chip_wp_bank #(
    .ADDR_W(ADDR_W),
    .NUM_WP(NUM_WP)
  ) u_wp (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (wp_cfg_we),
    .cfg_idx       (wp_cfg_idx),
    .cfg_addr      (wp_cfg_addr),
    .cfg_en        (wp_cfg_en),
    .cfg_mode      (wp_cfg_mode),
    .acc_valid     (bus_valid),
    .acc_write     (bus_write),
    .acc_in_window (in_window),
    .acc_bus_addr  (bus_addr),
    .acc_canon_addr(canon_addr),
    .hits          (wp_hit)
  );

  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:WIN_BITS] != '0) |-> (!ram_sel && !open_bus && !ram_we));

  // R5
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, open_bus}));

  // R5
  fit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && !size_sel) |-> (ram_offset[WIN_BITS-1:BASE_BITS] == '0));

  // R2
  reach_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_sel == REACH_512K) |-> (ram_offset[WIN_BITS-1:BASE_BITS] == '0));

  // R7
  hole_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_bus |-> !ram_we);

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> (cpu_rdata == IDLE_VALUE));

  // R8
  canon_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aliased && bus_addr[ADDR_W-1:WIN_BITS] == '0) |-> (canon_addr == bus_addr));

endmodule

// File: tb/chip_alias_decoder_tb.sv
`timescale 1ns/1ps
module chip_alias_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [1:0]  rev_sel = 2'd0;
  logic        size_sel = 1'b0;
  logic [15:0] ram_rdata = 16'h1234;
  logic [15:0] cpu_rdata;
  logic        ram_sel, open_bus, ram_we, aliased;
  logic [20:0] ram_offset;
  logic [23:0] canon_addr;
  logic        wp_cfg_we = 1'b0;
  logic [1:0]  wp_cfg_idx = '0;
  logic [23:0] wp_cfg_addr = '0;
  logic        wp_cfg_en = 1'b0;
  logic [1:0]  wp_cfg_mode = '0;
  logic [3:0]  wp_hit;

  int checks = 0;
  int fails = 0;

  logic [23:0] m_addr [4];
  logic        m_en   [4];
  logic [1:0]  m_mode [4];

  always #2.5 clk = ~clk;

  chip_alias_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .rev_sel(rev_sel), .size_sel(size_sel),
    .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .ram_sel(ram_sel),
    .open_bus(open_bus), .ram_we(ram_we), .ram_offset(ram_offset),
    .canon_addr(canon_addr), .aliased(aliased), .wp_cfg_we(wp_cfg_we),
    .wp_cfg_idx(wp_cfg_idx), .wp_cfg_addr(wp_cfg_addr), .wp_cfg_en(wp_cfg_en),
    .wp_cfg_mode(wp_cfg_mode), .wp_hit(wp_hit)
  );

  function automatic logic [23:0] exp_off(input logic [23:0] a, input logic [1:0] r);
    case (r)
      2'd0:    return a & 24'h07FFFF;
      2'd1:    return a & 24'h0FFFFF;
      default: return a & 24'h1FFFFF;
    endcase
  endfunction

  function automatic logic exp_win(input logic [23:0] a);
    return a < 24'h200000;
  endfunction

  function automatic logic exp_ram(input logic [23:0] a, input logic [1:0] r, input logic s);
    return exp_win(a) && (exp_off(a, r) < (s ? 24'h100000 : 24'h080000));
  endfunction

  function automatic logic [3:0] exp_hits(input logic [23:0] a, input logic [1:0] r, input logic w);
    logic [3:0] h;
    for (int k = 0; k < 4; k++)
      h[k] = exp_win(a) && m_en[k] && (w ? m_mode[k][1] : m_mode[k][0]) &&
             (m_addr[k] == a || m_addr[k] == exp_off(a, r));
    return h;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_wp(input int k, input logic [23:0] a, input logic en, input logic [1:0] md);
    @(negedge clk);
    wp_cfg_we = 1'b1; wp_cfg_idx = 2'(k); wp_cfg_addr = a; wp_cfg_en = en; wp_cfg_mode = md;
    @(negedge clk);
    wp_cfg_we = 1'b0;
    m_addr[k] = a; m_en[k] = en; m_mode[k] = md;
  endtask

  task automatic access(input logic [23:0] a, input logic [1:0] r, input logic s, input logic w);
    logic [23:0] off;
    logic        rs, win;
    logic [3:0]  eh;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; rev_sel = r; size_sel = s;
    ram_rdata = 16'($urandom);
    #1;
    off = exp_off(a, r); win = exp_win(a); rs = exp_ram(a, r, s);
    eh = exp_hits(a, r, w);
    if (r == 2'd0) check("R2 offset", 32'(ram_offset), 32'(off));
    else if (r == 2'd1) check("R3 offset", 32'(ram_offset), 32'(off));
    else check("R4 offset", 32'(ram_offset), 32'(off));
    check("R5 ram_sel", 32'(ram_sel), 32'(rs));
    check("R5 open_bus", 32'(open_bus), 32'(win && !rs));
    check("R7 ram_we", 32'(ram_we), 32'(w && rs));
    check("R7 cpu_rdata", 32'(cpu_rdata), rs ? 32'(ram_rdata) : 32'h0000FFFF);
    check("R8 canon", 32'(canon_addr), 32'(off));
    check("R8 aliased", 32'(aliased), 32'(win && off != a));
    if (!win) check("R1 outside", 32'({ram_sel, open_bus, ram_we}), 32'd0);
    @(posedge clk);
    #1;
    check("R10 wp_hit", 32'(wp_hit), 32'(eh));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    bus_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R10 single pulse", 32'(wp_hit), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin m_addr[k] = '0; m_en[k] = 1'b0; m_mode[k] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9 reset hits", 32'(wp_hit), 32'd0);
    rst_n = 1'b1;

    // Directed corners
    access(24'h0FFFFC, 2'd0, 1'b0, 1'b1);               // R6
    check("R6 offset", 32'(ram_offset), 32'h7FFFC);
    access(24'h080000, 2'd1, 1'b0, 1'b0);               // R5 hole
    check("R5 hole flag", 32'(open_bus), 32'd1);
    access(24'h100004, 2'd1, 1'b0, 1'b0);               // R3 repeat
    access(24'h180000, 2'd2, 1'b1, 1'b1);               // R4 hole in 2 MB reach
    access(24'h200000, 2'd0, 1'b0, 1'b1);               // R1
    access(24'hFFFFFE, 2'd2, 1'b1, 1'b0);               // R1

    // Watchpoint directed cases
    set_wp(0, 24'h07FFFC, 1'b1, 2'b10);                 // R9 write watch on canonical
    set_wp(1, 24'h100000, 1'b1, 2'b01);                 // read watch on alias
    set_wp(2, 24'h000010, 1'b0, 2'b11);                 // R11 disabled
    set_wp(3, 24'h000020, 1'b1, 2'b01);                 // R11 read-only
    access(24'h0FFFFC, 2'd0, 1'b0, 1'b1);
    check("R10 canonical hit", 32'(wp_hit[0]), 32'd1);
    idle_cycle();
    access(24'h100000, 2'd0, 1'b0, 1'b0);
    check("R10 alias hit", 32'(wp_hit[1]), 32'd1);
    access(24'h000010, 2'd0, 1'b0, 1'b0);
    check("R11 disabled", 32'(wp_hit[2]), 32'd0);
    access(24'h000020, 2'd0, 1'b0, 1'b1);
    check("R11 mode", 32'(wp_hit[3]), 32'd0);
    access(24'h200000 | 24'h07FFFC, 2'd0, 1'b0, 1'b1);
    check("R1 no hit outside", 32'(wp_hit), 32'd0);
    idle_cycle();

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a;
      int pick;
      if (n % 200 == 0)
        set_wp(int'($urandom_range(3)), 24'($urandom) & 24'h1FFFFE, 1'($urandom), 2'($urandom));
      pick = int'($urandom_range(9));
      if (pick < 6) a = 24'($urandom) & 24'h1FFFFF;
      else if (pick < 9)
        a = (m_addr[$urandom_range(3)] & 24'h07FFFF) | (24'($urandom_range(3)) << 19);
      else a = 24'($urandom);
      access(a, 2'($urandom), 1'($urandom), 1'($urandom));
      if (n % 7 == 0) idle_cycle();
    end
    idle_cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule